// File: doc/BRIEF.md
# Video Memory Slot Sequencer

This block lets one single-port video RAM serve two masters: the display engine, which must fetch a character code on a fixed schedule, and a CPU that writes at arbitrary times. A free-running phase counter on the pixel clock divides every eight-pixel character period into two halves. The first half belongs to the display: the display address is placed on the RAM address lines and the RAM is allowed to drive its data pins, and the code it returns is latched at the close of that half. The second half is a write window that the CPU may use.

The CPU side takes a write strobe together with an address, a data word and a decode flag that says whether the access targets video memory. Address and data are captured on any strobe that arrives while the block is idle. Only a decoded write becomes pending. The pending flag is sampled once per period, on the clock edge that closes the read half. If it is set, that period's write window drives the captured address and data, raises the write enable halfway through the window, and drops both when the window closes. A strobe that arrives while a write is still outstanding is reported as an overrun and discarded, so the held values stay intact.

Top module: `vram_slot_seq`

## Requirements
- R1: After reset the phase output counts 0,1,...,7 and wraps, advancing once per clock. The display output enable `disp_oe` is high exactly in phases 0 to 3, and during those phases `ram_addr` equals `disp_addr`.
- R2: A strobe accepted while `busy` is low captures address and data. It sets `busy` only if `cpu_sel` is 1. With `cpu_sel` at 0, no RAM write results and `busy` stays low.
- R3: Let p be the phase of the clock cycle in which an accepted video strobe is sampled. `busy` then stays high for 7-p cycles if p is 0, 1 or 2, and for 15-p cycles if p is 3 to 7. It drops on the edge that closes the serviced window.
- R4: In a serviced window, `cap_oe` is high for phases 4 to 7 and `ram_we` is high for phases 6 and 7 only. Both fall together after phase 7. Exactly one address, the captured one, receives the captured data.
- R5: `disp_oe` and `cap_oe` are never high in the same cycle.
- R6: In phases 4 to 7 with nothing pending, `cap_oe`, `ram_we` and `disp_oe` are all low.
- R7: A strobe sampled while `busy` is high makes `overrun` high for exactly the next cycle. The strobe is dropped, and the held address and data remain unchanged until the pending write completes.
- R8: `char_code` takes the value of `ram_rdata` on the edge that ends phase 3. `char_valid` is high only during phase 4.
- R9: While reset is held, `slot_phase` is 0 and `busy`, `overrun`, `cap_oe`, `ram_we` and `char_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle, synchronous to clk |
| cpu_sel | input | 1 | Decode result: 1 when the write targets video memory |
| cpu_addr | input | ADDR_W | CPU write address |
| cpu_data | input | DATA_W | CPU write data |
| disp_addr | input | ADDR_W | Display fetch address from the scan counters |
| ram_rdata | input | DATA_W | Data returned by the RAM during the read half |
| slot_phase | output | PHASE_W | Current phase within the character period |
| busy | output | 1 | A captured video write is outstanding |
| overrun | output | 1 | One-cycle pulse: a strobe arrived while busy and was dropped |
| disp_oe | output | 1 | Display-side drive enable (address counters and RAM output) |
| cap_oe | output | 1 | Captured-bus drive enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address while either drive enable is high |
| ram_wdata | output | DATA_W | Write data while cap_oe is high |
| char_code | output | DATA_W | Last fetched display code |
| char_valid | output | 1 | One-cycle pulse when char_code is refreshed |

## Verification
The bench places one write strobe in each of the eight phases, once with the decode flag set and once with it clear. It measures how long `busy` stays up, so a design that samples the pending flag at the wrong phase, or on the same edge that sets it, shows up as a wrong service latency. A RAM model records every write. An off-by-one in the write-enable placement is caught as a wrong strobe count, and a window that drives the bus with nothing pending is caught as a stray write. A second strobe is injected while a write is pending, and another lands inside the very window that is servicing the first. A design that lets a capture overwrite the held registers in either case writes to the wrong address.

// File: rtl/vss_pkg.sv
package vss_pkg;
  // Cycles that busy stays high after a video strobe sampled in phase p,
  // for a period of n phases split into equal read and write halves.
  function automatic int busy_span(int p, int n);
    if (p < n / 2 - 1) return n - 1 - p;
    return 2 * n - 1 - p;
  endfunction
endpackage

// File: rtl/vss_phase_gen.sv
module vss_phase_gen #(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PHASE_W-1:0] phase,
  output logic               read_half,
  output logic               at_check,
  output logic               at_last
);
  localparam int HALF = 1 << (PHASE_W - 1);
  localparam logic [PHASE_W-1:0] CHECK_PH = PHASE_W'(HALF - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign read_half = ~phase[PHASE_W-1];
  assign at_check  = (phase == CHECK_PH);
  assign at_last   = &phase;
endmodule

// File: rtl/vss_capture.sv
module vss_capture #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic              cpu_sel,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              done,
  output logic [ADDR_W-1:0] held_addr,
  output logic [DATA_W-1:0] held_data,
  output logic              pending,
  output logic              overrun
);
  logic accept;
  assign accept = cpu_we & ~pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_data <= '0;
      pending   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      overrun <= cpu_we & pending;
      if (done) begin
        pending <= 1'b0;
      end else if (accept) begin
        held_addr <= cpu_addr;
        held_data <= cpu_data;
        pending   <= cpu_sel;
      end
    end
  end
endmodule

// File: rtl/vss_slot_ctrl.sv
module vss_slot_ctrl #(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase,
  input  logic               at_check,
  input  logic               at_last,
  input  logic               pending,
  output logic               slot_act,
  output logic               we_out,
  output logic               done
);
  localparam int HALF = 1 << (PHASE_W - 1);
  localparam logic [PHASE_W-1:0] WE_PH = PHASE_W'(HALF + HALF / 2);

  always_ff @(posedge clk) begin
    if (!rst_n)        slot_act <= 1'b0;
    else if (at_check) slot_act <= pending;
    else if (at_last)  slot_act <= 1'b0;
  end

  assign we_out = slot_act & (phase >= WE_PH);
  assign done   = slot_act & at_last;
endmodule

// File: rtl/vram_slot_seq.sv
module vram_slot_seq #(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_we,
  input  logic               cpu_sel,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic [ADDR_W-1:0]  disp_addr,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic [PHASE_W-1:0] slot_phase,
  output logic               busy,
  output logic               overrun,
  output logic               disp_oe,
  output logic               cap_oe,
  output logic               ram_we,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [DATA_W-1:0]  ram_wdata,
  output logic [DATA_W-1:0]  char_code,
  output logic               char_valid
);
  // named internal events, also observed by the bound checker
  logic              read_half, at_check, at_last;
  logic              pending, slot_act, we_int, done;
  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] held_data;

  vss_phase_gen #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(slot_phase),
    .read_half(read_half), .at_check(at_check), .at_last(at_last)
  );

  vss_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .done(done),
    .held_addr(held_addr), .held_data(held_data),
    .pending(pending), .overrun(overrun)
  );

  vss_slot_ctrl #(.PHASE_W(PHASE_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .phase(slot_phase), .at_check(at_check),
    .at_last(at_last), .pending(pending), .slot_act(slot_act),
    .we_out(we_int), .done(done)
  );

  assign busy    = pending;
  assign disp_oe = read_half;
  assign cap_oe  = slot_act;
  assign ram_we  = we_int;

  always_comb begin
    ram_addr  = '0;
    ram_wdata = '0;
    if (read_half) begin
      ram_addr = disp_addr;
    end else if (slot_act) begin
      ram_addr  = held_addr;
      ram_wdata = held_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      char_code  <= '0;
      char_valid <= 1'b0;
    end else begin
      char_valid <= at_check;
      if (at_check) char_code <= ram_rdata;
    end
  end
endmodule

// File: rtl/vss_chk.sv
module vss_chk #(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_we,
  input logic               cpu_sel,
  input logic [PHASE_W-1:0] slot_phase,
  input logic               busy,
  input logic               overrun,
  input logic               disp_oe,
  input logic               cap_oe,
  input logic               ram_we,
  input logic [ADDR_W-1:0]  held_addr,
  input logic [DATA_W-1:0]  held_data
);
  localparam int HALF = 1 << (PHASE_W - 1);
  localparam logic [PHASE_W-1:0] HALF_PH = PHASE_W'(HALF);

  logic [PHASE_W-1:0] strobe_ph;
  logic [PHASE_W+1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_ph <= '0;
      busy_cnt  <= '0;
    end else if (cpu_we && !busy && cpu_sel) begin
      strobe_ph <= slot_phase;
      busy_cnt  <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  // R5
  no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_oe && cap_oe));
  // R4
  we_inside_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> cap_oe);
  // R4
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_oe) |-> slot_phase == HALF_PH);
  // R1
  read_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_oe) |-> slot_phase == HALF_PH);
  // R6
  idle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_phase >= HALF_PH && !busy) |-> (!cap_oe && !ram_we && !disp_oe));
  // R7
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && busy) |=> overrun);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(held_addr) && $stable(held_data)));
  // R2
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !busy && !cpu_sel) |=> !busy);
  // R3
  service_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> int'(busy_cnt) == vss_pkg::busy_span(int'(strobe_ph), 1 << PHASE_W));
endmodule

bind vram_slot_seq vss_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
  .slot_phase(slot_phase), .busy(busy), .overrun(overrun),
  .disp_oe(disp_oe), .cap_oe(cap_oe), .ram_we(ram_we),
  .held_addr(held_addr), .held_data(held_data)
);

// File: tb/sim_vram_slot_seq.sv
module sim_vram_slot_seq;
  localparam int CLK_P   = 10;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int PHASE_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_we, cpu_sel;
  logic [ADDR_W-1:0] cpu_addr, disp_addr, ram_addr;
  logic [DATA_W-1:0] cpu_data, ram_rdata, ram_wdata, char_code;
  logic [PHASE_W-1:0] slot_phase;
  logic busy, overrun, disp_oe, cap_oe, ram_we, char_valid;

  int n_chk = 0, n_fail = 0, we_cnt = 0, bph = 0;
  bit finished = 0;

  always #(CLK_P / 2) clk = ~clk;

  vram_slot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHASE_W(PHASE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .disp_addr(disp_addr),
    .ram_rdata(ram_rdata), .slot_phase(slot_phase), .busy(busy),
    .overrun(overrun), .disp_oe(disp_oe), .cap_oe(cap_oe), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .char_code(char_code),
    .char_valid(char_valid)
  );

  function automatic logic [DATA_W-1:0] pre(int a);
    return DATA_W'(a * 7 + 3);
  endfunction

  // RAM model: preloaded while reset is held
  logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << ADDR_W); i++) mem[i] <= pre(i);
    end else if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      we_cnt <= we_cnt + 1;
    end
  end
  assign ram_rdata = disp_oe ? mem[ram_addr] : '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // per-cycle monitor, sampled a quarter period after the rising edge
  always @(posedge clk) begin
    automatic logic ran = rst_n;
    #(CLK_P / 4);
    if (!ran) bph = 0;
    else begin
      bph = (bph + 1) % 8;
      chk(slot_phase == PHASE_W'(bph), "R1 phase count", slot_phase, bph);
      chk(disp_oe == (bph < 4), "R1 read half enable", disp_oe, bph < 4);
      if (disp_oe) chk(ram_addr == disp_addr, "R1 display address", ram_addr, disp_addr);
      chk(!(disp_oe && cap_oe), "R5 drive overlap", {disp_oe, cap_oe}, 0);
      if (cap_oe) chk(bph >= 4, "R4 drive phase", bph, 4);
      if (ram_we) chk(cap_oe && bph >= 6, "R4 write enable phase", bph, 6);
      if (bph >= 4 && !busy) chk(!cap_oe && !ram_we, "R6 idle window", {cap_oe, ram_we}, 0);
    end
  end

  task automatic wait_phase(input int p);
    do @(negedge clk); while (bph != p);
  endtask

  task automatic strobe(input int a, input int d, input bit s);
    cpu_we = 1'b1; cpu_sel = s;
    cpu_addr = ADDR_W'(a); cpu_data = DATA_W'(d);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cpu_we = 0; cpu_sel = 0; cpu_addr = '0; cpu_data = '0; disp_addr = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(slot_phase == 0, "R9 phase", slot_phase, 0);
    chk(!busy, "R9 busy", busy, 0);
    chk(!overrun, "R9 overrun", overrun, 0);
    chk(!cap_oe, "R9 cap_oe", cap_oe, 0);
    chk(!ram_we, "R9 ram_we", ram_we, 0);
    chk(!char_valid, "R9 char_valid", char_valid, 0);
    rst_n = 1'b1;

    // R8 display fetch
    for (int k = 0; k < 4; k++) begin
      wait_phase(0);
      disp_addr = ADDR_W'(k * 5 + 1);
      wait_phase(4);
      chk(char_valid, "R8 valid pulse", char_valid, 1);
      chk(char_code == pre(k * 5 + 1), "R8 code", char_code, pre(k * 5 + 1));
      @(negedge clk);
      chk(!char_valid, "R8 valid width", char_valid, 0);
    end

    // R2 R3 R4 sweep: every strobe phase, decoded and not decoded
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 2; s++) begin
        automatic int a = 16 + p * 2 + s;
        automatic int d = 8'hA5 ^ (p * 16 + s * 3 + 1);
        automatic int w0 = we_cnt;
        automatic int n = 0;
        automatic int exp_n = (s == 0) ? 0 : ((p <= 2) ? 7 - p : 15 - p);
        wait_phase(p);
        strobe(a, d, s[0]);
        @(negedge clk);
        cpu_we = 1'b0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == exp_n, "R3 busy span", n, exp_n);
        repeat (9) @(negedge clk);
        if (s == 1) begin
          chk(mem[a] == DATA_W'(d), "R4 written data", mem[a], d);
          chk(we_cnt - w0 == 2, "R4 enable length", we_cnt - w0, 2);
        end else begin
          chk(mem[a] == pre(a), "R2 undecoded write ignored", mem[a], pre(a));
          chk(we_cnt - w0 == 0, "R2 no write strobe", we_cnt - w0, 0);
        end
      end
    end

    // R7 strobes while busy, including one inside the serving window
    begin
      automatic int w0 = we_cnt;
      wait_phase(3);
      strobe(50, 8'h5A, 1'b1);
      @(negedge clk); cpu_we = 1'b0;
      wait_phase(5);
      strobe(51, 8'hC3, 1'b1);
      @(negedge clk); cpu_we = 1'b0;
      chk(overrun, "R7 overrun pulse", overrun, 1);
      @(negedge clk);
      chk(!overrun, "R7 overrun width", overrun, 0);
      wait_phase(5);
      chk(cap_oe, "R4 window active", cap_oe, 1);
      strobe(52, 8'hFF, 1'b0);
      @(negedge clk); cpu_we = 1'b0;
      chk(overrun, "R7 overrun in window", overrun, 1);
      while (busy) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(mem[50] == 8'h5A, "R7 held data kept", mem[50], 8'h5A);
      chk(mem[51] == pre(51), "R7 dropped strobe", mem[51], pre(51));
      chk(mem[52] == pre(52), "R7 window strobe dropped", mem[52], pre(52));
      chk(we_cnt - w0 == 2, "R7 single write", we_cnt - w0, 2);
    end

    summary();
  end
endmodule